// File: doc/BRIEF.md
# Memory-Mapped SRAM Gating Controller

This block sits between a processor's asynchronous-style byte bus and a backed-up external static RAM. It carves the lowest 64 bytes out of a 17-bit byte address space for on-chip registers (14 clock registers followed by 50 bytes of user storage). It passes every other address through to the external SRAM by forwarding the chip enable and a conditioned output enable. For on-chip accesses it produces a select, a read-drive enable for the register file's output buffers, and a one-cycle write-commit pulse with the captured register offset.

It also guards both memories against supply loss. When power is reported bad, or an optional power-fail input is raised, all on-chip strobes are dropped at once. Both external strobes are forced high and the power-fail output goes low. When power returns, that protected state persists for a recovery hold (150 ms by default). The hold is counted on the block clock, which serves as the timing reference, and any power glitch during the hold starts it again.

Top module: `sram_gate_ctrl`

## Requirements
- R1: An access is on-chip when addr[16:6] is zero (addresses 0x00000 to 0x0003F). reg_sel is high when the block is enabled, ce_n is low and the address is on-chip. reg_addr always equals addr[5:0].
- R2: ram_oe_n equals oe_n only when the block is enabled, ce_n is low and the address is 0x00040 or above. In every other case it is 1.
- R3: ram_ce_n equals ce_n while the block is enabled and is 1 otherwise.
- R4: reg_rd (on-chip output drive) is high exactly when reg_sel is high, oe_n is low and we_n is high.
- R5: A low we_n holds reg_rd at 0 even while oe_n and ce_n are low on an on-chip address.
- R6: A write is the overlap of ce_n low and we_n low on an on-chip address. reg_wr is high for one clock cycle, in the first sampled cycle after the overlap ends by either signal rising, provided the block is still enabled. reg_wr_addr then holds the offset present at the last clock edge of the overlap.
- R7: When pwr_good is 0 or pwr_fail is 1, the outputs change without waiting for a clock edge: pfo_n is 0, ram_ce_n and ram_oe_n are 1, and reg_sel, reg_rd and reg_wr are 0.
- R8: The block is enabled, and pfo_n is 1, only after HOLD_CYC consecutive clock edges with good power, where HOLD_CYC = REF_HZ*HOLD_MS/1000.
- R9: A power-bad cycle during the recovery hold restarts the full HOLD_CYC count.
- R10: After synchronous reset the block is in the protected state: pfo_n is 0 and ram_ce_n is 1.
- R11: reg_clk_sel is high when reg_sel is high and addr is below 14 (a clock register). It is low for user bytes 14 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the timing reference for the recovery hold |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 17 | Byte address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pwr_good | input | 1 | Supply in tolerance |
| pwr_fail | input | 1 | Optional extra power-fail indication, active high |
| reg_sel | output | 1 | On-chip register window selected |
| reg_clk_sel | output | 1 | Selected register is one of the 14 clock registers |
| reg_rd | output | 1 | On-chip output drivers enabled |
| reg_wr | output | 1 | One-cycle on-chip write commit |
| reg_addr | output | 6 | Register offset of the current access |
| reg_wr_addr | output | 6 | Register offset of the committed write |
| ram_ce_n | output | 1 | External SRAM chip enable, active low |
| ram_oe_n | output | 1 | External SRAM output enable, active low |
| pfo_n | output | 1 | Power-fail output, low while protected |

## Verification
The checker watches several relationships on every cycle. The on-chip select never coexists with an active external output enable, and a low write enable always keeps the register drivers off. While power is bad every strobe is blocked and the power-fail output is low. The chip enable passes straight through whenever the block is unprotected, and a commit pulse never lasts two cycles. Three behaviours need the bench's scenarios: the exact length of the recovery hold, its restart after a glitch mid-hold, and the rule that the commit lands on whichever of chip enable or write enable rises first, together with the captured offset. The bench's reference model compares all outputs each cycle across reads, writes, window boundaries and power events.

// File: rtl/sram_gate_pkg.sv
package sram_gate_pkg;

    localparam int ADDR_W_DEF = 17;

    // Bus controls, active high inside the block
    typedef struct packed {
        logic chip;
        logic rd_en;
        logic wr_en;
    } bus_ctl_t;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_REG  = 2'd1,
        ACC_RAM  = 2'd2
    } acc_kind_t;

    function automatic bus_ctl_t to_ctl(input logic ce_n, input logic oe_n, input logic we_n);
        bus_ctl_t c;
        c.chip  = ~ce_n;
        c.rd_en = ~oe_n;
        c.wr_en = ~we_n;
        return c;
    endfunction

    function automatic int hold_cycles(input int ref_hz, input int hold_ms);
        int n;
        n = (ref_hz / 1000) * hold_ms + ((ref_hz % 1000) * hold_ms) / 1000;
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/sram_gate_hold.sv
module sram_gate_hold #(
    parameter int HOLD_CYC = 4915
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    output logic prot
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            prot_q <= 1'b1;
        end else if (!pwr_ok) begin
            cnt_q  <= '0;
            prot_q <= 1'b1;
        end else if (prot_q) begin
            if (cnt_q == LAST) begin
                prot_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign prot = prot_q;
endmodule

// File: rtl/sram_gate_decode.sv
module sram_gate_decode
    import sram_gate_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int WIN_AW   = 6,
    parameter int CLK_REGS = 14
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  bus_ctl_t          ctl,
    output acc_kind_t         kind,
    output logic              win_hit,
    output logic              clk_hit,
    output logic              rd_drive,
    output logic              ram_ce_n,
    output logic              ram_oe_n
);
    always_comb begin
        win_hit = (addr[ADDR_W-1:WIN_AW] == '0);
        clk_hit = win_hit && (addr[WIN_AW-1:0] < WIN_AW'(CLK_REGS));
        if (!en || !ctl.chip) begin
            kind = ACC_IDLE;
        end else if (win_hit) begin
            kind = ACC_REG;
        end else begin
            kind = ACC_RAM;
        end
        rd_drive = (kind == ACC_REG) && ctl.rd_en && !ctl.wr_en;
        ram_ce_n = en ? !ctl.chip : 1'b1;
        ram_oe_n = (kind == ACC_RAM) ? !ctl.rd_en : 1'b1;
    end
endmodule

// File: rtl/sram_gate_commit.sv
module sram_gate_commit #(
    parameter int OFS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             overlap,
    input  logic [OFS_W-1:0] ofs,
    output logic             commit,
    output logic [OFS_W-1:0] commit_ofs
);
    logic             open_q;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            ofs_q  <= '0;
        end else begin
            open_q <= overlap;
            if (overlap) begin
                ofs_q <= ofs;
            end
        end
    end

    assign commit     = open_q && en && !overlap;
    assign commit_ofs = ofs_q;
endmodule

// File: rtl/sram_gate_ctrl.sv
module sram_gate_ctrl
    import sram_gate_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int WIN_BYTES = 64,
    parameter int CLK_REGS  = 14,
    parameter int REF_HZ    = 32768,
    parameter int HOLD_MS   = 150
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              pwr_good,
    input  logic              pwr_fail,
    output logic              reg_sel,
    output logic              reg_clk_sel,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [5:0]        reg_addr,
    output logic [5:0]        reg_wr_addr,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              pfo_n
);
    localparam int WIN_AW   = $clog2(WIN_BYTES);
    localparam int HOLD_CYC = hold_cycles(REF_HZ, HOLD_MS);

    logic      pwr_ok, prot, en;
    bus_ctl_t  ctl;
    acc_kind_t kind;
    logic      win_hit, clk_hit, rd_drive, overlap;
    logic [WIN_AW-1:0] ofs;

    assign pwr_ok = pwr_good && !pwr_fail;
    assign en     = pwr_ok && !prot;
    assign ctl    = to_ctl(ce_n, oe_n, we_n);
    assign ofs    = addr[WIN_AW-1:0];

    sram_gate_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .pwr_ok (pwr_ok),
        .prot   (prot)
    );

    sram_gate_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .CLK_REGS(CLK_REGS)) u_dec (
        .en       (en),
        .addr     (addr),
        .ctl      (ctl),
        .kind     (kind),
        .win_hit  (win_hit),
        .clk_hit  (clk_hit),
        .rd_drive (rd_drive),
        .ram_ce_n (ram_ce_n),
        .ram_oe_n (ram_oe_n)
    );

    assign overlap = (kind == ACC_REG) && ctl.wr_en;

    logic [WIN_AW-1:0] wr_ofs;
    sram_gate_commit #(.OFS_W(WIN_AW)) u_commit (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .overlap    (overlap),
        .ofs        (ofs),
        .commit     (reg_wr),
        .commit_ofs (wr_ofs)
    );

    assign reg_sel     = (kind == ACC_REG);
    assign reg_clk_sel = reg_sel && clk_hit;
    assign reg_rd      = rd_drive;
    assign reg_addr    = 6'(ofs);
    assign reg_wr_addr = 6'(wr_ofs);
    assign pfo_n       = en;
endmodule

// File: rtl/sram_gate_checker.sv
module sram_gate_checker #(
    parameter int HOLD_CYC = 4915
) (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic we_n,
    input logic pwr_good,
    input logic pwr_fail,
    input logic reg_sel,
    input logic reg_rd,
    input logic reg_wr,
    input logic ram_ce_n,
    input logic ram_oe_n,
    input logic pfo_n
);
    int good_run;
    always_ff @(posedge clk) begin
        if (rst || !pwr_good || pwr_fail) good_run <= 0;
        else if (good_run < HOLD_CYC) good_run <= good_run + 1;
    end

    p_oe_blocked_in_window_r2: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> ram_oe_n);

    p_ce_passes_r3: assert property (@(posedge clk) disable iff (rst)
        pfo_n |-> (ram_ce_n == ce_n));

    p_we_kills_drive_r5: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !reg_rd);

    p_commit_single_r6: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    p_powerfail_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (!pwr_good || pwr_fail) |-> (ram_ce_n && ram_oe_n && !reg_sel && !reg_rd && !reg_wr && !pfo_n));

    p_hold_complete_r8: assert property (@(posedge clk) disable iff (rst)
        pfo_n |-> (good_run >= HOLD_CYC));
endmodule

bind sram_gate_ctrl sram_gate_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .pwr_good (pwr_good),
    .pwr_fail (pwr_fail),
    .reg_sel  (reg_sel),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .ram_ce_n (ram_ce_n),
    .ram_oe_n (ram_oe_n),
    .pfo_n    (pfo_n)
);

// File: tb/tb_sram_gate_ctrl.sv
`timescale 1ns/100ps
module tb_sram_gate_ctrl;
    localparam int HOLD = 20;

    logic        clk = 0;
    logic        rst = 1;
    logic [16:0] addr = '0;
    logic        ce_n = 1, oe_n = 1, we_n = 1, pwr_good = 0, pwr_fail = 0;
    logic        reg_sel, reg_clk_sel, reg_rd, reg_wr, ram_ce_n, ram_oe_n, pfo_n;
    logic [5:0]  reg_addr, reg_wr_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sram_gate_ctrl #(.REF_HZ(1000), .HOLD_MS(HOLD)) dut (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .pwr_good(pwr_good), .pwr_fail(pwr_fail), .reg_sel(reg_sel),
        .reg_clk_sel(reg_clk_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wr_addr(reg_wr_addr), .ram_ce_n(ram_ce_n),
        .ram_oe_n(ram_oe_n), .pfo_n(pfo_n)
    );

    // Behavioural reference state
    int         good_cnt = 0;
    bit         m_open = 0;
    logic [5:0] m_ofs = '0;
    int         commits = 0;

    function automatic bit m_en();
        return pwr_good && !pwr_fail && (good_cnt >= HOLD);
    endfunction
    function automatic bit m_win();
        return addr < 17'h40;
    endfunction
    function automatic bit m_overlap();
        return m_en() && !ce_n && !we_n && m_win();
    endfunction

    always @(posedge clk) begin
        bit ov;
        ov = m_overlap();
        if (rst) begin
            good_cnt = 0; m_open = 0; m_ofs = '0;
        end else begin
            m_open = ov;
            if (ov) m_ofs = addr[5:0];
            if (!pwr_good || pwr_fail) good_cnt = 0;
            else if (good_cnt < HOLD) good_cnt++;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit en, win, sel;
        en  = m_en();
        win = m_win();
        sel = en && !ce_n && win;
        chk("R1 reg_sel", reg_sel, sel);
        chk("R1 reg_addr", reg_addr, addr[5:0]);
        chk("R2 ram_oe_n", ram_oe_n, (en && !ce_n && !win) ? oe_n : 1);
        chk("R3 ram_ce_n", ram_ce_n, en ? ce_n : 1);
        chk("R4 reg_rd", reg_rd, sel && !oe_n && we_n);
        chk("R6 reg_wr", reg_wr, m_open && en && !m_overlap());
        if (reg_wr) chk("R6 reg_wr_addr", reg_wr_addr, m_ofs);
        chk("R8 pfo_n", pfo_n, en);
        chk("R11 reg_clk_sel", reg_clk_sel, sel && (addr < 14));
    endtask

    task automatic cyc(input logic [16:0] a, input logic c, input logic o, input logic w,
                       input logic pg, input logic pf);
        @(negedge clk);
        addr = a; ce_n = c; oe_n = o; we_n = w; pwr_good = pg; pwr_fail = pf;
        #1;
        compare_all();
        if (reg_wr) commits++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(17'h0, 1, 1, 1, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; pwr_good = 1;
        #1;
        // R10: protected after reset
        chk("R10 pfo_n after reset", pfo_n, 0);
        chk("R10 ram_ce_n after reset", ram_ce_n, 1);
        // R8: hold counts out
        for (int i = 0; i < HOLD - 2; i++) cyc(17'h0, 0, 0, 1, 1, 0);
        chk("R8 still held", pfo_n, 0);
        idle(4);
        chk("R8 released", pfo_n, 1);

        // R1/R4/R11 reads across window
        cyc(17'h00005, 0, 0, 1, 1, 0);
        chk("R11 clock reg", reg_clk_sel, 1);
        cyc(17'h0000E, 0, 0, 1, 1, 0);
        chk("R11 user byte", reg_clk_sel, 0);
        cyc(17'h0003F, 0, 0, 1, 1, 0);
        chk("R4 top of window drives", reg_rd, 1);
        cyc(17'h00040, 0, 0, 1, 1, 0);
        chk("R2 first external oe", ram_oe_n, 0);
        chk("R1 external not sel", reg_sel, 0);
        cyc(17'h1FFFF, 0, 0, 1, 1, 0);
        cyc(17'h1FFFF, 1, 0, 1, 1, 0);
        chk("R2 ce high blocks oe", ram_oe_n, 1);

        // R5: write enable with oe low
        cyc(17'h00020, 0, 0, 0, 1, 0);
        chk("R5 drivers off", reg_rd, 0);
        cyc(17'h00020, 0, 0, 0, 1, 0);
        // end by we rising
        cyc(17'h00020, 0, 1, 1, 1, 0);
        chk("R6 commit on we rise", reg_wr, 1);
        chk("R6 commit addr", reg_wr_addr, 6'h20);
        cyc(17'h00020, 1, 1, 1, 1, 0);
        chk("R6 single pulse", reg_wr, 0);
        // end by ce rising
        cyc(17'h00007, 0, 1, 0, 1, 0);
        cyc(17'h00007, 0, 1, 0, 1, 0);
        cyc(17'h00007, 1, 1, 0, 1, 0);
        chk("R6 commit on ce rise", reg_wr, 1);
        chk("R6 commit addr ce", reg_wr_addr, 6'h07);
        // external write: no commit
        cyc(17'h00100, 0, 1, 0, 1, 0);
        cyc(17'h00100, 1, 1, 1, 1, 0);
        chk("R6 no commit external", reg_wr, 0);
        chk("R6 commit count", commits, 2);

        // R7: power loss mid-write drops commit
        cyc(17'h00011, 0, 1, 0, 1, 0);
        cyc(17'h00011, 0, 0, 0, 0, 0);
        chk("R7 ce blocked", ram_ce_n, 1);
        chk("R7 pfo low", pfo_n, 0);
        cyc(17'h00011, 1, 1, 1, 0, 0);
        chk("R7 no commit after loss", reg_wr, 0);
        chk("R6 commit count after loss", commits, 2);

        // R9: glitch during hold restarts
        for (int i = 0; i < HOLD - 5; i++) cyc(17'h00200, 0, 0, 1, 1, 0);
        cyc(17'h00200, 0, 0, 1, 1, 1);
        chk("R7 pwr_fail input blocks oe", ram_oe_n, 1);
        for (int i = 0; i < HOLD - 1; i++) cyc(17'h00200, 0, 0, 1, 1, 0);
        chk("R9 still held after restart", pfo_n, 0);
        cyc(17'h00200, 0, 0, 1, 1, 0);
        cyc(17'h00200, 0, 0, 1, 1, 0);
        chk("R9 released after full hold", pfo_n, 1);
        chk("R3 ce passes after hold", ram_ce_n, 0);

        // R10: reset returns to protected
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; #1;
        chk("R10 pfo_n after second reset", pfo_n, 0);
        idle(HOLD + 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule